// File: doc/BRIEF.md
# Multicycle Fetch-Decode-Execute Sequencer

This block is the control unit of a small stored-program processor. Code and data share one memory. The block steps a program counter, a memory address register, a memory buffer register and an instruction register through fetch, decode and execute. Each register transfer takes its own clock step.

The memory is external, synchronous and single-port, with one cycle of read latency. The block reaches it through:
- an address bus, driven from the memory address register;
- a write-data bus, driven from the memory buffer register;
- a read-data bus;
- an access enable;
- a read/not-write strobe.

The operation set is kept to the minimum needed to exercise the sequencing: load, store, add-immediate, jump, call and return. An accumulator holds the data value. Load, store, jump and call can take their operand indirectly. An indirect operand costs one extra memory read that fetches the effective address.

Call and return keep return addresses in a stack inside the shared memory. The stack grows downward from the top address. The stack pointer always points at the most recently pushed entry.

Top module: `fde_sequencer`

## Requirements
- R1: A synchronous active-high reset sets these values: PC 0, stack pointer all ones, accumulator 0, IR 0, memory enable low, strobe at read. The first fetch read appears in the first cycle after the first clock edge with reset low.
- R2: Fetch takes five cycles:
  - a cycle in which MAR takes PC;
  - a read cycle at PC, with the strobe high;
  - a cycle in which MBR takes the read data;
  - a cycle in which IR takes MBR;
  - a decode cycle.
  PC still holds the fetched address during the decode cycle and becomes that address plus one on the next cycle.
- R3: An instruction word is ADDR_W+4 bits wide:
  - bits [ADDR_W+3:ADDR_W] are the opcode; decode looks at no other bits;
  - the opcode top bit is the indirect flag;
  - the low three opcode bits select the operation: 0 no-op, 1 load, 2 store, 3 add-immediate, 4 jump, 5 call, 6 return, 7 undefined;
  - the low ADDR_W bits are the operand.
- R4: With a direct operand, the effective address is the operand field. Execute starts in the cycle right after decode.
- R5: With an indirect operand (the flag is set on load, store, jump or call), three cycles are inserted after decode. These include one read at the operand address, whose low ADDR_W data bits become the effective address.
- R6: Load reads memory at the effective address one cycle after execute starts. The accumulator takes the data, and the next fetch read comes five cycles after execute starts.
- R7: Store writes the accumulator to the effective address, with the strobe low, one cycle after execute starts. The next fetch read comes three cycles after execute starts.
- R8: Add-immediate adds the zero-extended operand to the accumulator, modulo 2^(ADDR_W+4). It makes no memory access and ignores the indirect flag. The next fetch read comes two cycles after execute starts.
- R9: Jump loads PC with the effective address. The next fetch read comes two cycles after execute starts.
- R10: Call first decrements the stack pointer. It then writes the incremented PC, zero-extended, at the new stack pointer one cycle after execute starts, and loads PC with the effective address. The next fetch read comes three cycles after execute starts.
- R11: Return reads at the stack pointer one cycle after execute starts. PC takes the low ADDR_W bits of that data and the stack pointer increments. It ignores the indirect flag. The next fetch read comes five cycles after execute starts.
- R12: The no-op and the undefined operation ignore the indirect flag and make no access beyond the fetch. The next fetch read comes five cycles after the previous one.
- R13: The memory enable is high only in the access cycles listed in R2 and R5 to R11, one access per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | output | 1 | Memory access enable (registered) |
| mem_rnw | output | 1 | 1 = read, 0 = write (registered) |
| mem_addr | output | ADDR_W | Memory address, from MAR |
| mem_wdata | output | ADDR_W+4 | Write data, from MBR |
| mem_rdata | input | ADDR_W+4 | Read data, valid the cycle after a read access |
| pc_o | output | ADDR_W | Program counter |
| sp_o | output | ADDR_W | Stack pointer |
| acc_o | output | ADDR_W+4 | Accumulator |
| ir_o | output | ADDR_W+4 | Instruction register |

## Verification
The bench sweeps all sixteen opcode values with several operands and runs a directed program. It compares every memory access against a cycle-exact instruction model, checking the cycle, the direction, the address and the write data. A PC that increments when it is copied to MAR fails the check that PC still holds the fetched address during decode. A stack pointer that decrements after the push, rather than before, writes the return address one entry too high and then pops the wrong entry.

Honouring the indirect flag on add-immediate, return, no-op or the undefined code inserts a read that the bench does not expect. An undefined code that hangs, or that falls into some execute state, misses the next fetch read five cycles later.

// File: rtl/fde_pkg.sv
package fde_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_ADDI  = 3'd3,
    OP_JUMP  = 3'd4,
    OP_CALL  = 3'd5,
    OP_RET   = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;

  typedef enum logic [4:0] {
    S_F_MAR, S_F_RD, S_F_MBR, S_F_IR, S_F_DEC,
    S_I_MAR, S_I_RD, S_I_MBR,
    S_LD_MAR, S_LD_RD, S_LD_MBR, S_LD_ACC,
    S_ST_MAR, S_ST_WR,
    S_ADDI, S_JUMP,
    S_C_PUSH, S_C_WR,
    S_R_MAR, S_R_RD, S_R_MBR, S_R_PC
  } seq_state_e;

  typedef enum logic [2:0] {MAR_HOLD, MAR_PC, MAR_OPND, MAR_EA, MAR_SPDN, MAR_SP} mar_sel_e;
  typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_ACC, MBR_PC} mbr_sel_e;
  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_EA, PC_MBR} pc_sel_e;
  typedef enum logic [1:0] {EA_HOLD, EA_OPND, EA_MEM} ea_sel_e;
  typedef enum logic [1:0] {ACC_HOLD, ACC_MBR, ACC_ADDI} acc_sel_e;
  typedef enum logic [1:0] {SP_HOLD, SP_DEC, SP_INC} sp_sel_e;

  typedef struct packed {
    mar_sel_e mar;
    mbr_sel_e mbr;
    logic     ir_we;
    pc_sel_e  pc;
    ea_sel_e  ea;
    acc_sel_e acc;
    sp_sel_e  sp;
  } ctrl_t;

  function automatic logic is_access(seq_state_e s);
    return s inside {S_F_RD, S_I_RD, S_LD_RD, S_ST_WR, S_C_WR, S_R_RD};
  endfunction

  function automatic logic is_write(seq_state_e s);
    return s inside {S_ST_WR, S_C_WR};
  endfunction

endpackage

// File: rtl/fde_decode.sv
module fde_decode
  import fde_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output op_e              op,
  output logic             ind
);

  always_comb begin
    op  = op_e'(opc[OPC_W-2:0]);
    // the indirect flag only matters for operations that use an address
    ind = opc[OPC_W-1] & (op inside {OP_LOAD, OP_STORE, OP_JUMP, OP_CALL});
  end

endmodule

// File: rtl/fde_fsm.sv
module fde_fsm
  import fde_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  op_e        op,
  input  logic       ind,
  output seq_state_e state_q,
  output ctrl_t      ctrl,
  output logic       mem_en_q,
  output logic       mem_rnw_q
);

  seq_state_e state_n;

  function automatic seq_state_e exec_entry(op_e o);
    unique case (o)
      OP_LOAD:  return S_LD_MAR;
      OP_STORE: return S_ST_MAR;
      OP_JUMP:  return S_JUMP;
      OP_CALL:  return S_C_PUSH;
      default:  return S_F_MAR;
    endcase
  endfunction

  always_comb begin
    ctrl    = '0;
    state_n = state_q;
    unique case (state_q)
      S_F_MAR:  begin ctrl.mar = MAR_PC;  state_n = S_F_RD;  end
      S_F_RD:   state_n = S_F_MBR;
      S_F_MBR:  begin ctrl.mbr = MBR_MEM; state_n = S_F_IR;  end
      S_F_IR:   begin ctrl.ir_we = 1'b1;  state_n = S_F_DEC; end
      S_F_DEC: begin
        ctrl.pc = PC_INC;
        ctrl.ea = EA_OPND;
        unique case (op)
          OP_ADDI: state_n = S_ADDI;
          OP_RET:  state_n = S_R_MAR;
          OP_LOAD, OP_STORE, OP_JUMP, OP_CALL:
                   state_n = ind ? S_I_MAR : exec_entry(op);
          default: state_n = S_F_MAR;
        endcase
      end
      S_I_MAR:  begin ctrl.mar = MAR_OPND; state_n = S_I_RD; end
      S_I_RD:   state_n = S_I_MBR;
      S_I_MBR:  begin ctrl.mbr = MBR_MEM; ctrl.ea = EA_MEM; state_n = exec_entry(op); end
      S_LD_MAR: begin ctrl.mar = MAR_EA;  state_n = S_LD_RD;  end
      S_LD_RD:  state_n = S_LD_MBR;
      S_LD_MBR: begin ctrl.mbr = MBR_MEM; state_n = S_LD_ACC; end
      S_LD_ACC: begin ctrl.acc = ACC_MBR; state_n = S_F_MAR;  end
      S_ST_MAR: begin ctrl.mar = MAR_EA;  ctrl.mbr = MBR_ACC; state_n = S_ST_WR; end
      S_ST_WR:  state_n = S_F_MAR;
      S_ADDI:   begin ctrl.acc = ACC_ADDI; state_n = S_F_MAR; end
      S_JUMP:   begin ctrl.pc = PC_EA;     state_n = S_F_MAR; end
      S_C_PUSH: begin
        ctrl.mar = MAR_SPDN;
        ctrl.mbr = MBR_PC;
        ctrl.sp  = SP_DEC;
        state_n  = S_C_WR;
      end
      S_C_WR:   begin ctrl.pc = PC_EA; state_n = S_F_MAR; end
      S_R_MAR:  begin ctrl.mar = MAR_SP; state_n = S_R_RD; end
      S_R_RD:   state_n = S_R_MBR;
      S_R_MBR:  begin ctrl.mbr = MBR_MEM; state_n = S_R_PC; end
      S_R_PC:   begin ctrl.pc = PC_MBR; ctrl.sp = SP_INC; state_n = S_F_MAR; end
      default:  state_n = S_F_MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_F_MAR;
      mem_en_q  <= 1'b0;
      mem_rnw_q <= 1'b1;
    end else begin
      state_q   <= state_n;
      mem_en_q  <= is_access(state_n);
      mem_rnw_q <= ~is_write(state_n);
    end
  end

endmodule

// File: rtl/fde_datapath.sv
module fde_datapath
  import fde_pkg::*;
#(
  parameter  int ADDR_W = 8,
  localparam int WORD_W = ADDR_W + OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mar_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic [WORD_W-1:0] mbr_q,
  output logic [WORD_W-1:0] ir_q,
  output logic [WORD_W-1:0] acc_q
);

  localparam logic [ADDR_W-1:0] SP_TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] ea_q;
  logic [ADDR_W-1:0] operand;

  assign operand = ir_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      pc_q  <= '0;
      ea_q  <= '0;
      acc_q <= '0;
      sp_q  <= SP_TOP;
    end else begin
      unique case (ctrl.mar)
        MAR_PC:   mar_q <= pc_q;
        MAR_OPND: mar_q <= operand;
        MAR_EA:   mar_q <= ea_q;
        MAR_SPDN: mar_q <= sp_q - 1'b1;
        MAR_SP:   mar_q <= sp_q;
        default:  ;
      endcase
      unique case (ctrl.mbr)
        MBR_MEM: mbr_q <= mem_rdata;
        MBR_ACC: mbr_q <= acc_q;
        MBR_PC:  mbr_q <= WORD_W'(pc_q);
        default: ;
      endcase
      if (ctrl.ir_we) ir_q <= mbr_q;
      unique case (ctrl.pc)
        PC_INC:  pc_q <= pc_q + 1'b1;
        PC_EA:   pc_q <= ea_q;
        PC_MBR:  pc_q <= mbr_q[ADDR_W-1:0];
        default: ;
      endcase
      unique case (ctrl.ea)
        EA_OPND: ea_q <= operand;
        EA_MEM:  ea_q <= mem_rdata[ADDR_W-1:0];
        default: ;
      endcase
      unique case (ctrl.acc)
        ACC_MBR:  acc_q <= mbr_q;
        ACC_ADDI: acc_q <= acc_q + WORD_W'(operand);
        default:  ;
      endcase
      unique case (ctrl.sp)
        SP_DEC:  sp_q <= sp_q - 1'b1;
        SP_INC:  sp_q <= sp_q + 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer
  import fde_pkg::*;
#(
  parameter  int ADDR_W = 8,
  localparam int WORD_W = ADDR_W + OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_en,
  output logic              mem_rnw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [WORD_W-1:0] ir_o
);

  seq_state_e state_w;
  ctrl_t      ctrl_w;
  op_e        op_w;
  logic       ind_w;

  fde_decode u_decode (
    .opc (ir_o[WORD_W-1:ADDR_W]),
    .op  (op_w),
    .ind (ind_w)
  );

  fde_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .op        (op_w),
    .ind       (ind_w),
    .state_q   (state_w),
    .ctrl      (ctrl_w),
    .mem_en_q  (mem_en),
    .mem_rnw_q (mem_rnw)
  );

  fde_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl_w),
    .mem_rdata (mem_rdata),
    .mar_q     (mem_addr),
    .pc_q      (pc_o),
    .sp_q      (sp_o),
    .mbr_q     (mem_wdata),
    .ir_q      (ir_o),
    .acc_q     (acc_o)
  );

endmodule

// File: rtl/fde_sequencer_chk.sv
module fde_sequencer_chk
  import fde_pkg::*;
#(
  parameter  int ADDR_W = 8,
  localparam int WORD_W = ADDR_W + OPC_W
) (
  input logic              clk,
  input logic              rst,
  input seq_state_e        state_w,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic [WORD_W-1:0] acc_o,
  input logic [WORD_W-1:0] ir_o,
  input logic              mem_en,
  input logic              mem_rnw,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_rdata
);

  logic rst_seen_q = 1'b0;

  always @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q) begin
      assert_reset_state_R1: assert (pc_o == '0 && sp_o == {ADDR_W{1'b1}} &&
                                     acc_o == '0 && ir_o == '0 && !mem_en)
        else $error("reset state wrong");
    end
  end

  assert_fetch_read_R2: assert property (@(posedge clk) disable iff (rst)
    state_w == S_F_RD |-> (mem_en && mem_rnw && mem_addr == pc_o));

  assert_ir_load_R2: assert property (@(posedge clk) disable iff (rst)
    state_w == S_F_IR |=> ir_o == $past(mem_rdata, 2));

  assert_pc_late_inc_R2: assert property (@(posedge clk) disable iff (rst)
    state_w == S_F_DEC |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  assert_write_in_exec_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_rnw) |-> (state_w == S_ST_WR || state_w == S_C_WR));

  assert_push_dec_R10: assert property (@(posedge clk) disable iff (rst)
    state_w == S_C_PUSH |=> sp_o == ADDR_W'($past(sp_o) - 1'b1));

  assert_pop_inc_R11: assert property (@(posedge clk) disable iff (rst)
    state_w == S_R_PC |=> sp_o == ADDR_W'($past(sp_o) + 1'b1));

  assert_no_stray_access_R13: assert property (@(posedge clk) disable iff (rst)
    !(state_w inside {S_F_RD, S_I_RD, S_LD_RD, S_ST_WR, S_C_WR, S_R_RD}) |-> !mem_en);

  assert_acc_hold_on_store_R7: assert property (@(posedge clk) disable iff (rst)
    state_w == S_ST_WR |=> $stable(acc_o));

endmodule

bind fde_sequencer fde_sequencer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .state_w   (state_w),
  .pc_o      (pc_o),
  .sp_o      (sp_o),
  .acc_o     (acc_o),
  .ir_o      (ir_o),
  .mem_en    (mem_en),
  .mem_rnw   (mem_rnw),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata)
);

// File: tb/fde_sequencer_tb_top.sv
module fde_sequencer_tb_top;

  localparam int AW    = 8;
  localparam int WW    = AW + 4;
  localparam int DEPTH = 1 << AW;
  localparam int LOGN  = 4096;
  localparam int EVN   = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mem_en, mem_rnw;
  logic [AW-1:0] mem_addr, pc_o, sp_o;
  logic [WW-1:0] mem_wdata, acc_o, ir_o;
  logic [WW-1:0] rdata_q = '0;

  always #4 clk = ~clk;

  fde_sequencer #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .mem_en(mem_en), .mem_rnw(mem_rnw),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdata_q),
    .pc_o(pc_o), .sp_o(sp_o), .acc_o(acc_o), .ir_o(ir_o)
  );

  logic [WW-1:0] tbmem [DEPTH];
  logic [WW-1:0] mm    [DEPTH];
  logic [WW-1:0] pm    [DEPTH];

  always @(posedge clk) begin
    if (mem_en) begin
      if (!mem_rnw) tbmem[mem_addr] <= mem_wdata;
      else          rdata_q <= tbmem[mem_addr];
    end
  end

  // cycle-indexed capture of the outputs
  logic live = 1'b0;
  int   cyc, a_n;
  logic [AW-1:0] pc_log [LOGN];
  logic [AW-1:0] sp_log [LOGN];
  logic [WW-1:0] acc_log[LOGN];
  logic [WW-1:0] ir_log [LOGN];
  int            a_cyc [EVN];
  logic          a_rnw [EVN];
  logic [AW-1:0] a_addr[EVN];
  logic [WW-1:0] a_dat [EVN];

  always @(posedge clk) live <= !rst;

  always @(negedge clk) begin
    if (live) begin
      cyc = cyc + 1;
      if (cyc < LOGN) begin
        pc_log[cyc] = pc_o; sp_log[cyc] = sp_o;
        acc_log[cyc] = acc_o; ir_log[cyc] = ir_o;
      end
      if (mem_en && a_n < EVN) begin
        a_cyc[a_n] = cyc; a_rnw[a_n] = mem_rnw;
        a_addr[a_n] = mem_addr; a_dat[a_n] = mem_wdata;
        a_n = a_n + 1;
      end
    end
  end

  // expected accesses and fetch points
  int            e_n;
  int            e_cyc [EVN];
  logic          e_rnw [EVN];
  logic [AW-1:0] e_addr[EVN];
  logic [WW-1:0] e_dat [EVN];
  string         e_tag [EVN];
  int            f_t   [64];
  logic [AW-1:0] f_pc  [64];
  logic [AW-1:0] f_sp  [64];
  logic [WW-1:0] f_w   [64];
  logic [WW-1:0] f_acc [64];
  string         f_tag [64];

  int nchk = 0;
  int nerr = 0;
  bit ended = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic add_ev(input int c, input logic r, input logic [AW-1:0] a,
                        input logic [WW-1:0] d, input string tag);
    if (e_n < EVN) begin
      e_cyc[e_n] = c; e_rnw[e_n] = r; e_addr[e_n] = a; e_dat[e_n] = d; e_tag[e_n] = tag;
      e_n++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pc_o == '0, "R1", "reset pc", pc_o, 0);
    check(sp_o == '1, "R1", "reset sp", sp_o, 8'hFF);
    check(acc_o == '0, "R1", "reset acc", acc_o, 0);
    check(ir_o == '0, "R1", "reset ir", ir_o, 0);
    check(!mem_en && mem_rnw, "R1", "reset strobes", {mem_en, mem_rnw}, 2'b01);
    cyc = 0;
    a_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      tbmem[i] = pm[i];
      mm[i]    = pm[i];
    end
    @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // instruction-level model: builds the expected trace, then compares it
  task automatic run_prog(input int n);
    int            t, e, nx, t_end, m, guard;
    logic [AW-1:0] pc, sp, ea, opnd, pcn;
    logic [WW-1:0] acc, w;
    logic [3:0]    opc;
    logic [2:0]    op;
    bit            ind;
    string         tg, ptg;
    do_reset();
    t = 1; pc = '0; sp = '1; acc = '0; e_n = 0; ptg = "R1";
    for (int i = 0; i <= n; i++) begin
      w = mm[pc];
      f_t[i] = t; f_pc[i] = pc; f_w[i] = w; f_acc[i] = acc; f_sp[i] = sp; f_tag[i] = ptg;
      add_ev(t, 1'b1, pc, '0, "R2");
      if (i == n) break;
      opc  = w[WW-1:AW];
      op   = opc[2:0];
      opnd = w[AW-1:0];
      pcn  = pc + 1'b1;
      ind  = opc[3] && (op == 3'd1 || op == 3'd2 || op == 3'd4 || op == 3'd5);
      e  = t + 4;
      ea = opnd;
      tg = ind ? "R5" : "R4";
      if (ind) begin
        add_ev(t + 5, 1'b1, opnd, '0, "R5");
        ea = mm[opnd][AW-1:0];
        e  = t + 7;
      end
      case (op)
        3'd1: begin
          add_ev(e + 1, 1'b1, ea, '0, {"R6/", tg});
          acc = mm[ea]; nx = e + 5; ptg = "R6";
        end
        3'd2: begin
          add_ev(e + 1, 1'b0, ea, acc, {"R7/", tg});
          mm[ea] = acc; nx = e + 3; ptg = "R7";
        end
        3'd3: begin
          acc = acc + {4'h0, opnd}; nx = e + 2; ptg = "R8";
        end
        3'd4: begin
          pcn = ea; nx = e + 2; ptg = {"R9/", tg};
        end
        3'd5: begin
          sp = sp - 1'b1;
          add_ev(e + 1, 1'b0, sp, {4'h0, pcn}, {"R10/", tg});
          mm[sp] = {4'h0, pcn}; pcn = ea; nx = e + 3; ptg = "R10";
        end
        3'd6: begin
          add_ev(e + 1, 1'b1, sp, '0, "R11");
          pcn = mm[sp][AW-1:0]; sp = sp + 1'b1; nx = e + 5; ptg = "R11";
        end
        default: begin
          nx = t + 5; ptg = "R12";
        end
      endcase
      pc = pcn;
      t  = nx;
    end
    t_end = f_t[n];
    guard = 0;
    while (cyc < t_end + 5 && guard < 4000) begin
      @(posedge clk);
      guard++;
    end
    @(negedge clk);
    #1;
    check(guard < 4000, "R13", "run stalled", guard, 4000);
    m = 0;
    for (int k = 0; k < a_n; k++) if (a_cyc[k] <= t_end) m++;
    check(m == e_n, "R13", "access count", m, e_n);
    for (int k = 0; k < e_n && k < m; k++) begin
      check(a_cyc[k] == e_cyc[k], e_tag[k], "access cycle", a_cyc[k], e_cyc[k]);
      check(a_rnw[k] == e_rnw[k] && a_addr[k] == e_addr[k], e_tag[k], "access dir/addr",
            {a_rnw[k], a_addr[k]}, {e_rnw[k], e_addr[k]});
      if (!e_rnw[k])
        check(a_dat[k] == e_dat[k], e_tag[k], "write data", a_dat[k], e_dat[k]);
    end
    for (int i = 0; i <= n; i++) begin
      t = f_t[i];
      check(pc_log[t] == f_pc[i], f_tag[i], "pc at fetch", pc_log[t], f_pc[i]);
      check(acc_log[t] == f_acc[i], f_tag[i], "acc at fetch", acc_log[t], f_acc[i]);
      check(sp_log[t] == f_sp[i], f_tag[i], "sp at fetch", sp_log[t], f_sp[i]);
      check(ir_log[t + 3] == f_w[i], "R3", "ir after fetch", ir_log[t + 3], f_w[i]);
      check(pc_log[t + 3] == f_pc[i], "R2", "pc held in decode", pc_log[t + 3], f_pc[i]);
      check(pc_log[t + 4] == AW'(f_pc[i] + 1'b1), "R2", "pc incremented",
            pc_log[t + 4], AW'(f_pc[i] + 1'b1));
    end
  endtask

  initial begin
    // directed program: every operation, both addressing kinds, nested calls
    for (int a = 0; a < DEPTH; a++) pm[a] = '0;
    pm[8'h00] = 12'h180;  // load 80
    pm[8'h01] = 12'h305;  // add 5
    pm[8'h02] = 12'h281;  // store 81
    pm[8'h03] = 12'h982;  // load via 82
    pm[8'h04] = 12'h540;  // call 40
    pm[8'h05] = 12'h700;  // undefined
    pm[8'h06] = 12'hF33;  // undefined, flag set
    pm[8'h07] = 12'hA83;  // store via 83
    pm[8'h08] = 12'hC84;  // jump via 84
    pm[8'h40] = 12'h550;  // nested call 50
    pm[8'h41] = 12'h600;  // return
    pm[8'h50] = 12'h3FF;  // add FF
    pm[8'h51] = 12'h600;  // return
    pm[8'h60] = 12'hD85;  // call via 85
    pm[8'h61] = 12'hB10;  // add 10, flag ignored
    pm[8'h62] = 12'h190;  // load 90
    pm[8'h63] = 12'h463;  // jump to self
    pm[8'h70] = 12'hE00;  // return, flag ignored
    pm[8'h80] = 12'h7F3;
    pm[8'h82] = 12'h081;
    pm[8'h83] = 12'h090;
    pm[8'h84] = 12'h060;
    pm[8'h85] = 12'h070;
    run_prog(24);

    // sweep: every opcode code with several operands, then pseudo-random code
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 3; s++) begin
        for (int a = 0; a < DEPTH; a++)
          pm[a] = WW'((a * 113) ^ ((a * 29) >> 1) ^ 12'h5A5);
        pm[0] = {4'(c), (s == 0) ? 8'h3C : (s == 1) ? 8'hA7 : 8'hFF};
        run_prog(6);
      end
    end

    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!ended) begin
      ended = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule